// File: doc/BRIEF.md
# Programmable Square-Wave Buzzer Driver

This block produces a square wave with an exact 50% duty cycle, meant to drive a piezo or magnetic buzzer from a single pin. The input clock is first divided down by a power-of-two ratio picked from four settings. The divided ticks then advance a 6-bit counter. Each time the counter reaches the programmed period value, the output flips and the counter restarts from zero. The output frequency is therefore the divided clock rate over 2 × (period + 1).

Period data can be rewritten while the tone is playing. The block keeps an internal copy of the period that it is actually comparing against. A new value that is not below the running count takes effect at once. A new value below the running count is held back until the current half-cycle wraps, so the counter never has to run through all 64 states to catch up. When the enable is low, the output stays low and the divider and counter stay cleared. Each enable starts a fresh wave with the output low.

Top module: `sqwave_buzzer`

## Requirements
- R1: During reset, and in the cycle after any clock edge sampled with `enable` low, `buzz_out` is 0. Changes on `period_in` or `div_sel` while disabled leave it at 0.
- R2: After `enable` rises, `buzz_out` stays 0 until the first wrap. The first rising edge of `buzz_out` follows the N-th clock edge with enable high, where N = D × (P + 1).
- R3: With a constant period P (0 to 63), `buzz_out` toggles every D × (P + 1) clocks, giving equal high and low times. This holds at the boundaries P = 0 and P = 63.
- R4: `div_sel` sets the tick divisor D: code 0 gives 8, code 1 gives 16, code 2 gives 32 and code 3 gives 64. The counter changes only on a divided tick.
- R5: A new `period_in` value that is at or above the current count is used from the next tick. If it equals the current count, the wrap happens on that next tick.
- R6: A new `period_in` value below the current count does not shorten the running half-cycle. That half-cycle ends at the old period, and the new period governs every half-cycle after it.
- R7: The count never exceeds the period value being compared against, so no half-cycle runs past it.
- R8: `buzz_out` changes only on a divided tick while enabled, or through R1 when disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the tone when high; when low, clears the divider and counter and holds the output low |
| div_sel | input | 2 | Clock divider code: 0 → /8, 1 → /16, 2 → /32, 3 → /64 |
| period_in | input | 6 | Period value P; each half-cycle lasts P + 1 divided ticks |
| buzz_out | output | 1 | Square-wave output to the buzzer |

## Verification
The hardest cases to reach are the two reload cases, because the effect of a period write depends on the internal count at the moment of the write. The bench starts each of these runs from an enable edge. From that edge, the count at any clock is fixed by the divisor. The bench then writes the new period on a chosen cycle, so the count at that moment is known to be below, equal to or above the new value. A scoreboard holds the expected clock number of every output toggle. This catches a reload that lands one half-cycle early or late.

// File: rtl/buzz_pkg.sv
// Shared sizing for the buzzer driver.
// Assumes: base divide ratio is a power of two, at least 2.
package buzz_pkg;
    localparam int unsigned BZ_PERIOD_W  = 6;  // width of count and period data
    localparam int unsigned BZ_SEL_W     = 2;  // width of divider select
    localparam int unsigned BZ_BASE_LOG2 = 3;  // select code 0 divides by 2**3

    // Divider select codes; code n divides by 2**(BZ_BASE_LOG2+n)
    typedef enum logic [BZ_SEL_W-1:0] {
        DIV_BY_8  = 2'd0,
        DIV_BY_16 = 2'd1,
        DIV_BY_32 = 2'd2,
        DIV_BY_64 = 2'd3
    } buzz_div_e;
endpackage

// File: rtl/buzz_prescaler.sv
// Clock prescaler: a free-running binary counter, cleared while disabled.
// A tick is raised when the low (BASE_LOG2 + div_sel) bits are all ones,
// so a tick appears once every 2**(BASE_LOG2 + div_sel) enabled clocks.
// Assumes: BASE_LOG2 >= 1.
module buzz_prescaler #(
    parameter int unsigned SEL_W     = buzz_pkg::BZ_SEL_W,
    parameter int unsigned BASE_LOG2 = buzz_pkg::BZ_BASE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int unsigned NUM_SEL = 1 << SEL_W;
    localparam int unsigned PRE_W   = BASE_LOG2 + NUM_SEL - 1;

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_SEL-1:0] tick_opt;

    // Advance the prescaler while enabled, clear it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One candidate tick per divide ratio
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_ratio
        assign tick_opt[g] = &pre_q[BASE_LOG2+g-1:0];
    end

    // Pick the ratio chosen by the select code
    always_comb begin
        tick = enable & tick_opt[div_sel];
    end
endmodule

// File: rtl/buzz_period_buf.sv
// Period buffer: holds the period value in force and applies the reload rule.
// A new value at or above the current count is used at once; a lower one is
// held off until the count wraps to zero, where any value is at or above it.
// Assumes: the counter never exceeds the value presented on eff_period.
module buzz_period_buf #(
    parameter int unsigned W = buzz_pkg::BZ_PERIOD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] period_in,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] act_q,
    output logic [W-1:0] eff_period
);
    logic accept_new;

    // Decide whether the incoming period is safe to use right now
    always_comb begin
        accept_new = (period_in >= cnt);
        eff_period = accept_new ? period_in : act_q;
    end

    // Track the period in force; follow the input freely while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!enable) begin
            act_q <= period_in;
        end else begin
            act_q <= eff_period;
        end
    end
endmodule

// File: rtl/buzz_wave_counter.sv
// Tick counter and output flip-flop. On each tick the count rises by one,
// or on a match with the effective period it wraps to zero and the output
// flips. Both clear while disabled, so each enable starts with output low.
// Assumes: cnt_q <= eff_period on every enabled cycle.
module buzz_wave_counter #(
    parameter int unsigned W = buzz_pkg::BZ_PERIOD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic [W-1:0] eff_period,
    output logic [W-1:0] cnt_q,
    output logic         wave_q
);
    logic wrap;

    // Detect the end of a half-cycle
    always_comb begin
        wrap = tick && (cnt_q == eff_period);
    end

    // Count divided ticks, restarting at the period match
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // Flip the output at every period match
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            wave_q <= 1'b0;
        end else if (wrap) begin
            wave_q <= ~wave_q;
        end
    end
endmodule

// File: rtl/sqwave_buzzer.sv
// Top of the buzzer driver: prescaler, period buffer and wave counter.
// Produces a 50% duty square wave of half-period D*(P+1) clocks.
// Assumes: synchronous active-low reset; inputs synchronous to clk.
module sqwave_buzzer #(
    parameter int unsigned PERIOD_W  = buzz_pkg::BZ_PERIOD_W,
    parameter int unsigned SEL_W     = buzz_pkg::BZ_SEL_W,
    parameter int unsigned BASE_LOG2 = buzz_pkg::BZ_BASE_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [SEL_W-1:0]    div_sel,
    input  logic [PERIOD_W-1:0] period_in,
    output logic                buzz_out
);
    logic                tick;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] act_q;
    logic [PERIOD_W-1:0] eff_period;
    logic                wave_q;

    buzz_prescaler #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_sel (div_sel),
        .tick    (tick)
    );

    buzz_period_buf #(
        .W (PERIOD_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .period_in  (period_in),
        .cnt        (cnt_q),
        .act_q      (act_q),
        .eff_period (eff_period)
    );

    buzz_wave_counter #(
        .W (PERIOD_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .eff_period (eff_period),
        .cnt_q      (cnt_q),
        .wave_q     (wave_q)
    );

    // Drive the pin straight from the output flip-flop
    always_comb begin
        buzz_out = wave_q;
    end
endmodule

// File: rtl/sqwave_buzzer_chk.sv
// Checker for the buzzer driver, bound into every sqwave_buzzer instance.
// Watches the pin, the divided tick and the count against the stored period.
module sqwave_buzzer_chk #(
    parameter int unsigned PERIOD_W = buzz_pkg::BZ_PERIOD_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                buzz_out,
    input logic                tick,
    input logic [PERIOD_W-1:0] cnt,
    input logic [PERIOD_W-1:0] act
);
    // R1: a disabled cycle leaves the output low and the count at zero
    assert_hold_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (buzz_out == 1'b0 && cnt == '0));

    // R7: the count stays within the stored period
    assert_no_runaway_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act);

    // R8: the output only moves on a divided tick while enabled
    assert_toggle_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(buzz_out));

    // R4: the count only moves on a divided tick while enabled
    assert_count_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(cnt));
endmodule

bind sqwave_buzzer sqwave_buzzer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .buzz_out (buzz_out),
    .tick     (tick),
    .cnt      (cnt_q),
    .act      (act_q)
);

// File: tb/sqwave_buzzer_tb.sv
`timescale 1ns/1ps
module sqwave_buzzer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [5:0] period_in = 6'd0;
    logic       buzz_out;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  c0 = 0;
    int  exp_q[$];
    bit  mon_on = 1'b0;
    bit  done = 1'b0;
    logic prev_out = 1'b0;
    string cur_req = "R3";

    sqwave_buzzer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .div_sel   (div_sel),
        .period_in (period_in),
        .buzz_out  (buzz_out)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    // Monitor: every output edge is compared with the next expected clock number
    always @(negedge clk) begin
        if (mon_on && buzz_out !== prev_out) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_req, " unexpected toggle"}, cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, {cur_req, " toggle time"}, cyc, e);
            end
        end
        prev_out = buzz_out;
    end

    // Driver: push the expected toggle clocks of a steady run
    task automatic push_run(input int base, input int d, input int p, input int n);
        for (int k = 1; k <= n; k++) exp_q.push_back(base + k * d * (p + 1));
    endtask

    task automatic start_run(input int sel, input int p, input string req);
        @(negedge clk);
        div_sel = sel[1:0];
        period_in = p[5:0];
        cur_req = req;
        @(negedge clk);
        enable = 1'b1;
        c0 = cyc;
        mon_on = 1'b1;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic finish_run();
        while (exp_q.size() != 0) @(negedge clk);
        mon_on = 1'b0;
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(buzz_out == 1'b0, "R1 low after disable", buzz_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(buzz_out == 1'b0, "R1 reset state", buzz_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: every divider code, P=2
        for (int s = 0; s < 4; s++) begin
            start_run(s, 2, "R4");
            push_run(c0, 8 << s, 2, 3);
            finish_run();
        end

        // R3: boundary periods
        start_run(0, 0, "R3");
        push_run(c0, 8, 0, 4);
        finish_run();
        start_run(0, 63, "R3");
        push_run(c0, 8, 63, 2);
        finish_run();

        // R2: output low until the first wrap
        start_run(1, 4, "R2");
        push_run(c0, 16, 4, 2);
        @(negedge clk);
        chk(buzz_out == 1'b0, "R2 low at start", buzz_out, 0);
        wait_cyc(c0 + 79);
        chk(buzz_out == 1'b0, "R2 low before first wrap", buzz_out, 0);
        finish_run();

        // R1: period and divider changes while disabled leave output low
        for (int i = 0; i < 4; i++) begin
            period_in = 6'(i * 7);
            div_sel = i[1:0];
            repeat (20) @(negedge clk);
            chk(buzz_out == 1'b0, "R1 held while disabled", buzz_out, 0);
        end

        // R5: raise above count at count 5 (20 -> 10), used at once
        start_run(0, 20, "R5");
        wait_cyc(c0 + 43);
        period_in = 6'd10;
        exp_q.push_back(c0 + 88);
        exp_q.push_back(c0 + 176);
        finish_run();

        // R5: new value equal to count 5 wraps on the next tick
        start_run(0, 20, "R5");
        wait_cyc(c0 + 43);
        period_in = 6'd5;
        exp_q.push_back(c0 + 48);
        exp_q.push_back(c0 + 96);
        finish_run();

        // R6: drop below count 15 (20 -> 5), deferred to the wrap
        start_run(0, 20, "R6");
        wait_cyc(c0 + 123);
        period_in = 6'd5;
        exp_q.push_back(c0 + 168);
        exp_q.push_back(c0 + 216);
        exp_q.push_back(c0 + 264);
        finish_run();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule